// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

The engine takes received Ethernet frames as a byte stream with a last-byte flag and places each one into host memory through a ring of 32-byte receive descriptors. When a frame begins, it reads three words of the current descriptor: control/ownership, buffer size with the end-of-ring flag, and buffer address. Input is held off with a ready signal during this read. Payload bytes are then packed into 32-bit little-endian words and written to the buffer with byte strobes.

When the frame ends, the engine decides what happens to it. A short frame is dropped with a receive-interrupt indication. A frame with no owned descriptor is dropped with a buffer-unavailable indication. A good frame gets its control word rewritten with the length plus four CRC bytes, and the ring pointer moves on. Single-cycle status pulses feed a shared status register elsewhere. Four 64-bit wrapping counters track good frames, their bytes, and their broadcast and multicast split. Software sets the ring pointer to the base address with a load strobe.

Top module: `rx_desc_writeback`

## Requirements
- R1: A frame whose first byte arrives while `rx_en` is low is consumed to its last byte with no memory access, no status pulse, no counter change and no pointer move.
- R2: From the start of a frame until the three descriptor words have been read, `in_ready` stays low. Each read takes at least two cycles.
- R3: A frame of fewer than 12 bytes pulses `st_ri` and `st_nis` and leaves the descriptor word, the pointer and the counters unchanged. This takes priority over the ownership check.
- R4: A frame of 12 bytes or more whose descriptor word 0 has bit 31 clear writes no payload and pulses `st_ru` and `st_ais` (not `st_ri`). It leaves the pointer and the counters unchanged.
- R5: For an owned descriptor, frame byte n is stored at byte address (word 2 of the descriptor) + n, in little-endian byte lanes.
- R6: On success, descriptor word 0 is rewritten as ((length + 4) << 16) | 0x300. The length field is bits 29:16, and bit 31 (ownership) ends up clear.
- R7: After a successful frame the pointer reloads from `rx_base` when bit 15 of descriptor word 1 is set. Otherwise it advances by 32.
- R8: A good frame counts as broadcast when its first six bytes are all 0xFF. It counts as multicast when bit 0 of its first byte is 1 and it is not broadcast. Otherwise it is unicast and neither counter moves.
- R9: Each good frame adds one to `cnt_frames` and adds length + 4 to `cnt_bytes`.
- R10: A successful frame pulses `st_ri` and `st_nis` for one cycle.
- R11: `base_load` copies `rx_base` into the descriptor pointer `cur_desc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| base_load | input | 1 | Load `rx_base` into the ring pointer |
| rx_base | input | AW | Ring base address |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Last byte of frame |
| in_ready | output | 1 | Input byte accepted when high with `in_valid` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Write byte enables |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid, the cycle after acceptance |
| mem_rdata | input | 32 | Read data |
| cur_desc | output | AW | Current descriptor address |
| st_ri | output | 1 | Receive-interrupt set pulse |
| st_nis | output | 1 | Normal-summary set pulse |
| st_ru | output | 1 | Buffer-unavailable set pulse |
| st_ais | output | 1 | Abnormal-summary set pulse |
| cnt_bytes | output | CW | Good-frame byte count, including the CRC allowance |
| cnt_frames | output | CW | Good-frame count |
| cnt_mcast | output | CW | Multicast good-frame count |
| cnt_bcast | output | CW | Broadcast good-frame count |

## Verification
Most internal faults show up at the ports within the frame that caused them. A wrong ownership or end-of-ring latch, or a wrong length register, shows up as a wrong status pulse, a bad descriptor word or a bad pointer a few cycles after the last byte. A lane or address error in the byte packer corrupts the stored payload of that same frame. A wrong classification flag is only seen in the counters after the frame ends. A stale pointer stays hidden until the next frame lands in the wrong descriptor, so the pointer is checked after every frame.

// File: rtl/rx_desc_writeback.sv
module rx_desc_writeback #(
  parameter int AW   = 32,
  parameter int LENW = 14,
  parameter int CW   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          base_load,
  input  logic [AW-1:0] rx_base,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_wstrb,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic [AW-1:0] cur_desc,
  output logic          st_ri,
  output logic          st_nis,
  output logic          st_ru,
  output logic          st_ais,
  output logic [CW-1:0] cnt_bytes,
  output logic [CW-1:0] cnt_frames,
  output logic [CW-1:0] cnt_mcast,
  output logic [CW-1:0] cnt_bcast
);

  localparam int DSTRIDE = 32;
  localparam int MINLEN  = 12;
  localparam int PADW    = 16 - LENW;

  typedef enum logic [2:0] {S_IDLE, S_DROP, S_FETCH, S_DATA, S_FLUSH, S_WB} state_t;

  state_t            state;
  logic [1:0]        fidx;
  logic              rd_wait, own, eor, grp, is_bc, wpend;
  logic [AW-1:0]     buf_addr, waddr;
  logic [LENW-1:0]   len;
  logic [31:0]       wword;
  logic [3:0]        wstrb;

  wire [1:0]      lane = len[1:0];
  wire [LENW-1:0] len4 = len + LENW'(4);
  wire [31:0]     wb_word = {{PADW{1'b0}}, len4, 16'h0300};
  wire            take = in_valid && in_ready;

  assign in_ready = (state == S_DROP) || (state == S_DATA && !wpend);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_desc;
    mem_wdata = wword;
    mem_wstrb = wstrb;
    case (state)
      S_FETCH: begin
        mem_req  = !rd_wait;
        mem_addr = cur_desc + {{(AW-4){1'b0}}, fidx, 2'b00};
      end
      S_DATA, S_FLUSH: begin
        mem_req  = wpend;
        mem_we   = wpend;
        mem_addr = waddr;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = wb_word;
        mem_wstrb = 4'hF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      fidx <= '0; rd_wait <= 1'b0; own <= 1'b0; eor <= 1'b0;
      grp <= 1'b0; is_bc <= 1'b0; wpend <= 1'b0;
      buf_addr <= '0; waddr <= '0; len <= '0; wword <= '0; wstrb <= '0;
      cur_desc <= '0;
      st_ri <= 1'b0; st_nis <= 1'b0; st_ru <= 1'b0; st_ais <= 1'b0;
      cnt_bytes <= '0; cnt_frames <= '0; cnt_mcast <= '0; cnt_bcast <= '0;
    end else begin
      st_ri <= 1'b0; st_nis <= 1'b0; st_ru <= 1'b0; st_ais <= 1'b0;
      case (state)
        S_IDLE:
          if (in_valid) begin
            state   <= rx_en ? S_FETCH : S_DROP;
            fidx    <= '0;
            rd_wait <= 1'b0;
          end
        S_DROP:
          if (take && in_last) state <= S_IDLE;
        S_FETCH: begin
          if (!rd_wait && mem_ready) rd_wait <= 1'b1;
          if (rd_wait && mem_rvalid) begin
            rd_wait <= 1'b0;
            fidx    <= fidx + 2'd1;
            case (fidx)
              2'd0:    own <= mem_rdata[31];
              2'd1:    eor <= mem_rdata[15];
              default: buf_addr <= mem_rdata[AW-1:0];
            endcase
            if (fidx == 2'd2) begin
              state <= S_DATA;
              len   <= '0;
              wpend <= 1'b0;
              is_bc <= 1'b1;
            end
          end
        end
        S_DATA: begin
          if (wpend && mem_ready) wpend <= 1'b0;
          if (take) begin
            wword[{lane, 3'b000} +: 8] <= in_data;
            wstrb <= ((lane == 2'd0) ? 4'b0000 : wstrb) | (4'b0001 << lane);
            if (len == '0) grp <= in_data[0];
            if (len < LENW'(6) && in_data != 8'hFF) is_bc <= 1'b0;
            if ((lane == 2'd3 || in_last) && own) begin
              wpend <= 1'b1;
              waddr <= buf_addr + AW'({len[LENW-1:2], 2'b00});
            end
            len <= len + LENW'(1);
            if (in_last) state <= S_FLUSH;
          end
        end
        S_FLUSH: begin
          if (wpend) begin
            if (mem_ready) wpend <= 1'b0;
          end else if (len < LENW'(MINLEN)) begin
            st_ri <= 1'b1; st_nis <= 1'b1;
            state <= S_IDLE;
          end else if (!own) begin
            st_ru <= 1'b1; st_ais <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_WB;
          end
        end
        S_WB:
          if (mem_ready) begin
            cur_desc   <= eor ? rx_base : cur_desc + AW'(DSTRIDE);
            cnt_frames <= cnt_frames + CW'(1);
            cnt_bytes  <= cnt_bytes + CW'(len4);
            if (is_bc) cnt_bcast <= cnt_bcast + CW'(1);
            else if (grp) cnt_mcast <= cnt_mcast + CW'(1);
            st_ri <= 1'b1; st_nis <= 1'b1;
            state <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
      if (base_load) cur_desc <= rx_base;
    end
  end

  assert_fetch_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !in_ready);

  assert_ru_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_ru |-> (st_ais && !st_ri && !st_nis));

  assert_ri_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_ri |-> st_nis);

  assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_frames) |-> (cnt_frames == $past(cnt_frames) + CW'(1) && st_ri));

  assert_ptr_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_desc) |-> ($past(base_load) || cur_desc == $past(rx_base)
                            || cur_desc == $past(cur_desc) + AW'(DSTRIDE)));

  assert_class_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_bcast) |-> $stable(cnt_mcast));

endmodule

// File: tb/rx_desc_writeback_test.sv
module rx_desc_writeback_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b1, base_load = 1'b0;
  logic [31:0] rx_base = 32'h100;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, mem_req, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_desc;
  logic [3:0] mem_wstrb;
  logic mem_ready;
  logic st_ri, st_nis, st_ru, st_ais;
  logic [63:0] cnt_bytes, cnt_frames, cnt_mcast, cnt_bcast;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_writeback uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .base_load(base_load), .rx_base(rx_base),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .cur_desc(cur_desc), .st_ri(st_ri), .st_nis(st_nis),
    .st_ru(st_ru), .st_ais(st_ais), .cnt_bytes(cnt_bytes), .cnt_frames(cnt_frames),
    .cnt_mcast(cnt_mcast), .cnt_bcast(cnt_bcast));

  logic [31:0] mem [0:1023];
  logic [1:0] rdy_cnt = 2'd0;
  logic tb_we = 1'b0;
  logic [31:0] tb_a = 32'h0, tb_d = 32'h0;
  assign mem_ready = (rdy_cnt != 2'd3);

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 2'd1;
    mem_rvalid <= 1'b0;
    if (tb_we) mem[tb_a[11:2]] <= tb_d;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_wstrb[i]) mem[mem_addr[11:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end
  end

  int total = 0, bad = 0;
  int expq [$];
  logic [7:0] fb [0:127];
  int stall;
  logic [31:0] exp_cur;
  logic [63:0] e_bytes = 0, e_frames = 0, e_mc = 0, e_bc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (st_ri || st_ru)) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R1 unexpected status pulse", {st_ri, st_nis, st_ru, st_ais}, 0);
      end else begin
        int k;
        k = expq.pop_front();
        if (k == 2) chk(st_ru && st_ais && !st_ri && !st_nis, "R4 status", {st_ri, st_nis, st_ru, st_ais}, 4'b0011);
        else chk(st_ri && st_nis && !st_ru && !st_ais, "R10/R3 status", {st_ri, st_nis, st_ru, st_ais}, 4'b1100);
      end
    end
  end

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    tb_a = a; tb_d = d; tb_we = 1'b1;
    @(posedge clk); #1 tb_we = 1'b0;
  endtask

  task automatic set_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
    poke(a, w0); poke(a + 4, w1); poke(a + 8, w2);
  endtask

  task automatic build(input int n, input logic [47:0] dst, input logic [7:0] seed);
    for (int k = 0; k < n; k++)
      fb[k] = (k < 6) ? dst[8*(5-k) +: 8] : seed + 8'(k * 7);
  endtask

  task automatic send(input int n);
    stall = 0;
    for (int k = 0; k < n; k++) begin
      bit hs;
      in_valid = 1'b1; in_data = fb[k]; in_last = (k == n - 1);
      hs = 1'b0;
      while (!hs) begin
        @(negedge clk); hs = in_ready;
        if (!hs && k == 0) stall++;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    repeat (40) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] peekb(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic good(input int n, input logic [31:0] d, input logic [31:0] b, input bit wrap, input int cls);
    int errs;
    expq.push_back(0);
    send(n);
    chk(mem[d[11:2]] == ((32'(n + 4) << 16) | 32'h300), "R6 status word", mem[d[11:2]], (32'(n + 4) << 16) | 32'h300);
    errs = 0;
    for (int k = 0; k < n; k++) if (peekb(b + 32'(k)) != fb[k]) errs++;
    chk(errs == 0, "R5 payload bytes", errs, 0);
    exp_cur = wrap ? rx_base : exp_cur + 32;
    chk(cur_desc == exp_cur, "R7 pointer", cur_desc, exp_cur);
    e_frames++; e_bytes += 64'(n + 4);
    if (cls == 2) e_bc++; else if (cls == 1) e_mc++;
    chk(cnt_frames == e_frames && cnt_bytes == e_bytes, "R9 frame/byte counters", {cnt_frames[31:0], cnt_bytes[31:0]}, {e_frames[31:0], e_bytes[31:0]});
    chk(cnt_mcast == e_mc && cnt_bcast == e_bc, "R8 class counters", {cnt_mcast[31:0], cnt_bcast[31:0]}, {e_mc[31:0], e_bc[31:0]});
  endtask

  task automatic quiet(input string tag);
    chk(cur_desc == exp_cur, tag, cur_desc, exp_cur);
    chk(cnt_frames == e_frames && cnt_bytes == e_bytes && cnt_mcast == e_mc && cnt_bcast == e_bc,
        tag, cnt_frames, e_frames);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!in_ready && !st_ri && !st_ru && cnt_frames == 0 && cnt_bytes == 0, "reset state", {in_ready, st_ri, st_ru}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1 base_load = 1'b1;
    @(posedge clk); #1 base_load = 1'b0;
    exp_cur = 32'h100;
    chk(cur_desc == 32'h100, "R11 base load", cur_desc, 32'h100);

    set_desc(32'h100, 32'h8000_0000, 32'h0, 32'h400);
    set_desc(32'h120, 32'h8000_0000, 32'h0, 32'h600);
    set_desc(32'h140, 32'h8000_0000, 32'h0000_8000, 32'h800);

    build(20, 48'h0211_2233_4455, 8'h10);
    good(20, 32'h100, 32'h400, 1'b0, 0);
    chk(stall >= 6, "R2 fetch back-pressure", stall, 6);

    build(13, 48'hFFFF_FFFF_FFFF, 8'h20);
    good(13, 32'h120, 32'h600, 1'b0, 2);

    build(64, 48'h0100_5E00_0001, 8'h30);
    good(64, 32'h140, 32'h800, 1'b1, 1);

    poke(32'h100, 32'h8000_0000);
    build(8, 48'h0211_2233_4455, 8'h40);
    expq.push_back(1);
    send(8);
    chk(mem[32'h100 >> 2] == 32'h8000_0000, "R3 short keeps descriptor", mem[32'h100 >> 2], 32'h8000_0000);
    quiet("R3 short pointer/counters");

    poke(32'h100, 32'h0);
    poke(32'h400, 32'hDEAD_BEEF);
    build(30, 48'h0211_2233_4455, 8'h50);
    expq.push_back(2);
    send(30);
    chk(mem[32'h400 >> 2] == 32'hDEAD_BEEF, "R4 no payload written", mem[32'h400 >> 2], 32'hDEAD_BEEF);
    quiet("R4 pointer/counters");

    rx_en = 1'b0;
    poke(32'h100, 32'h8000_0000);
    build(20, 48'hFFFF_FFFF_FFFF, 8'h60);
    send(20);
    rx_en = 1'b1;
    chk(mem[32'h400 >> 2] == 32'hDEAD_BEEF && mem[32'h100 >> 2] == 32'h8000_0000, "R1 disabled no memory write",
        mem[32'h400 >> 2], 32'hDEAD_BEEF);
    quiet("R1 disabled pointer/counters");

    poke(32'h100, 32'h0);
    build(5, 48'h0211_2233_4455, 8'h70);
    expq.push_back(1);
    send(5);
    quiet("R3 short beats ownership");

    poke(32'h100, 32'h8000_0000);
    build(12, 48'h0211_2233_4455, 8'h80);
    good(12, 32'h100, 32'h400, 1'b0, 0);

    poke(32'h120, 32'h8000_0000);
    build(40, 48'hFFFF_FFFF_FFFE, 8'h90);
    good(40, 32'h120, 32'h600, 1'b0, 1);

    chk(expq.size() == 0, "R10 all status pulses seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule